// File: doc/BRIEF.md
# Interrupt Pin Capture and Message Delivery

This block sits between a bank of device interrupt lines and a message-signalled interrupt fabric. Each of its input pins has a 64-bit routing entry, supplied as a flat bus by a neighbouring register block. The entry selects edge or level sensing, masking, a vector, a delivery type and a destination. Incoming requests are captured into a pending register. Legacy line 0 is folded onto pin 2, and every other line maps straight to its own pin.

A scanner walks the pins from the lowest index to the highest. Each pin found deliverable is turned into one 32-bit address and one 32-bit data word, offered on a valid/ready handshake. An edge pin is consumed when it is delivered. A level pin instead sets a per-pin "in service" flag, and that flag blocks any further delivery from the pin until an end-of-interrupt carrying the pin's vector clears it. A pass over the pins starts after any pending-bit change, any in-service clear, or an update strobe from the register block. A request that arrives during a pass queues one more pass.

Top module: `irq_route_engine`

## Requirements
- R1: A request on input line 0 acts as a request on pin 2, using pin 2's entry. Pin 0 never becomes pending.
- R2: For a pin whose trigger bit (entry bit 15) is 1, meaning level, the pending state follows the line. A line held high is delivered once. A line that is low at the time of the end-of-interrupt produces no further message.
- R3: Delivering a level pin sets its bit of `remote_irr`. While that bit is set, the pin sends nothing. An end-of-interrupt whose vector differs from the pin's vector (entry bits 7:0) leaves the bit set. An end-of-interrupt with a matching vector clears it, and if the line is still high the pin is delivered again.
- R4: For an edge pin (bit 15 = 0) whose mask bit (entry bit 16) is 1, a rising request is discarded. Unmasking the pin afterwards produces no message.
- R5: A rising request on an unmasked edge pin produces exactly one message.
- R6: A masked level pin with its line high stays pending and sends nothing. Clearing its mask and pulsing `redir_upd` delivers it.
- R7: The message address is 0xFEE00000 OR (destination, entry bits 63:48, shifted left 4) OR (destination-mode bit, entry bit 11, shifted left 2). The message data is vector[7:0] OR (delivery type, entry bits 10:8, shifted left 8) OR (trigger bit shifted left 15).
- R8: Pins that become pending in the same cycle are delivered in ascending pin order.
- R9: Only one message is outstanding. While `msg_valid` is high and `msg_ready` is low, the address and data hold steady and nothing else is sent.
- R10: When a pin's entry is set to edge trigger, its `remote_irr` bit clears.
- R11: After reset, `msg_valid` and every `remote_irr` bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Interrupt request lines |
| redir_flat | input | NUM_PINS*64 | Routing entries, pin i at bits [64*i +: 64] |
| redir_upd | input | 1 | One-cycle strobe after any entry changes |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken on a cycle with valid high |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| remote_irr | output | NUM_PINS | Per-pin in-service flags |

## Verification
The assertions assume that `redir_flat` changes only together with a `redir_upd` pulse, and that `msg_ready` is an ordinary level that is never X. The stall check also assumes that a stalled message is not withdrawn. The bench programs entries only through a task that always pulses the strobe. It drives every input one nanosecond after a rising edge, and it drops ready only in the back-pressure scenario. Every entry starts masked, so that unused pins stay quiet.

// File: rtl/irqdlv_pkg.sv
package irqdlv_pkg;
  localparam int ENTRY_W  = 64;
  localparam int VEC_LSB  = 0;
  localparam int DLV_LSB  = 8;
  localparam int DMODE_B  = 11;
  localparam int TRIG_B   = 15;
  localparam int MASK_B   = 16;
  localparam int DEST_LSB = 48;

  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        level;
    logic        dmode;
    logic [2:0]  dlv;
    logic [7:0]  vec;
  } rte_t;

  function automatic logic [31:0] make_addr(rte_t e);
    return {12'hFEE, e.dest, 1'b0, e.dmode, 2'b00};
  endfunction

  function automatic logic [31:0] make_data(rte_t e);
    return {16'h0000, e.level, 4'h0, e.dlv, e.vec};
  endfunction
endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture #(
  parameter int NUM_PINS  = 24,
  parameter int STEER_SRC = 0,
  parameter int STEER_DST = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] level_vec,
  input  logic [NUM_PINS-1:0] mask_vec,
  input  logic [NUM_PINS-1:0] clr_vec,
  output logic [NUM_PINS-1:0] pend_q,
  output logic                pend_chg
);
  logic [NUM_PINS-1:0] req, prev_q, pend_d;

  always_comb begin
    req = irq_in;
    req[STEER_SRC] = 1'b0;
    req[STEER_DST] = irq_in[STEER_DST] | irq_in[STEER_SRC];
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_comb begin
      if (level_vec[i]) pend_d[i] = req[i];
      else pend_d[i] = (pend_q[i] & ~clr_vec[i]) | (req[i] & ~prev_q[i] & ~mask_vec[i]);
    end

    // R4: an edge pin only becomes pending while unmasked
    p_edge_masked_r4: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !$past(pend_q[i]) && !$past(level_vec[i])) |-> !$past(mask_vec[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      pend_q   <= '0;
      pend_chg <= 1'b0;
    end else begin
      prev_q   <= req;
      pend_q   <= pend_d;
      pend_chg <= (pend_d != pend_q);
    end
  end

  // R5: the scanner consumes at most one edge pin per cycle
  p_clr_onehot_r5: assert property (@(posedge clk) disable iff (rst) $onehot0(clr_vec));
endmodule

// File: rtl/irq_msg_scanner.sv
module irq_msg_scanner
  import irqdlv_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PTR_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  rte_t                cfg [NUM_PINS],
  input  logic [NUM_PINS-1:0] pend_q,
  input  logic                kick,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  input  logic                msg_ready,
  output logic [NUM_PINS-1:0] clr_vec,
  output logic [NUM_PINS-1:0] rirr_q,
  output logic                msg_valid,
  output logic [31:0]         msg_addr,
  output logic [31:0]         msg_data
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_PINS - 1);

  logic [PTR_W-1:0]    ptr_q;
  logic                busy_q, again_q;
  logic [NUM_PINS-1:0] level_vec, rirr_clr, rirr_set;
  logic                adv, deliver, trig;
  rte_t                cur;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lvl
    assign level_vec[i] = cfg[i].level;
    assign rirr_clr[i]  = ~cfg[i].level | (eoi_valid & (cfg[i].vec == eoi_vector));
  end

  assign cur     = cfg[ptr_q];
  assign adv     = !msg_valid || msg_ready;
  assign deliver = busy_q && adv && pend_q[ptr_q] && !cur.mask &&
                   (!cur.level || !rirr_q[ptr_q]);
  assign trig    = kick || |(rirr_q & rirr_clr & level_vec);

  always_comb begin
    clr_vec  = '0;
    rirr_set = '0;
    if (deliver) begin
      if (cur.level) rirr_set[ptr_q] = 1'b1;
      else clr_vec[ptr_q] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      busy_q    <= 1'b0;
      again_q   <= 1'b0;
      rirr_q    <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      rirr_q <= (rirr_q & ~rirr_clr) | rirr_set;
      if (!busy_q) begin
        if (trig || again_q) begin
          busy_q  <= 1'b1;
          ptr_q   <= '0;
          again_q <= 1'b0;
        end
      end else if (adv) begin
        if (ptr_q == LAST) begin
          ptr_q   <= '0;
          busy_q  <= trig || again_q;
          again_q <= 1'b0;
        end else begin
          ptr_q <= ptr_q + 1'b1;
          if (trig) again_q <= 1'b1;
        end
      end else if (trig) begin
        again_q <= 1'b1;
      end
      if (deliver) begin
        msg_valid <= 1'b1;
        msg_addr  <= make_addr(cur);
        msg_data  <= make_data(cur);
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  // R9: a stalled message stays put
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
  // R7: every offered address carries the fixed base
  p_addr_base_r7: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[31:20] == 12'hFEE));
  // R10: no in-service flag survives on a pin that was edge-configured
  p_rirr_edge_r10: assert property (@(posedge clk) disable iff (rst)
    (rirr_q & ~$past(level_vec)) == '0);
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irqdlv_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int STEER_SRC = 0,
  parameter int STEER_DST = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PINS-1:0]         irq_in,
  input  logic [NUM_PINS*ENTRY_W-1:0] redir_flat,
  input  logic                        redir_upd,
  input  logic                        eoi_valid,
  input  logic [7:0]                  eoi_vector,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output logic [31:0]                 msg_addr,
  output logic [31:0]                 msg_data,
  output logic [NUM_PINS-1:0]         remote_irr
);
  rte_t                cfg [NUM_PINS];
  logic [NUM_PINS-1:0] level_vec, mask_vec, clr_vec, pend_q;
  logic                pend_chg;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_dec
    logic [ENTRY_W-1:0] e;
    logic               unused_bits;
    assign e = redir_flat[i*ENTRY_W +: ENTRY_W];
    assign cfg[i].vec   = e[VEC_LSB +: 8];
    assign cfg[i].dlv   = e[DLV_LSB +: 3];
    assign cfg[i].dmode = e[DMODE_B];
    assign cfg[i].level = e[TRIG_B];
    assign cfg[i].mask  = e[MASK_B];
    assign cfg[i].dest  = e[DEST_LSB +: 16];
    assign level_vec[i] = e[TRIG_B];
    assign mask_vec[i]  = e[MASK_B];
    assign unused_bits  = ^{e[47:17], e[14:12]};
  end

  irq_pin_capture #(
    .NUM_PINS(NUM_PINS), .STEER_SRC(STEER_SRC), .STEER_DST(STEER_DST)
  ) u_cap (
    .clk(clk), .rst(rst), .irq_in(irq_in), .level_vec(level_vec),
    .mask_vec(mask_vec), .clr_vec(clr_vec), .pend_q(pend_q), .pend_chg(pend_chg)
  );

  irq_msg_scanner #(.NUM_PINS(NUM_PINS)) u_scan (
    .clk(clk), .rst(rst), .cfg(cfg), .pend_q(pend_q),
    .kick(pend_chg | redir_upd), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_ready(msg_ready), .clr_vec(clr_vec), .rirr_q(remote_irr),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: tb/irq_route_engine_bench.sv
`timescale 1ns/1ps
module irq_route_engine_bench;
  localparam int N = 24;
  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic [63:0] ent [N];
  logic [N*64-1:0] redir_flat;
  logic redir_upd = 1'b0, eoi_valid = 1'b0, msg_ready = 1'b1;
  logic [7:0] eoi_vector = '0;
  logic msg_valid;
  logic [31:0] msg_addr, msg_data;
  logic [N-1:0] remote_irr;
  int total = 0, fails = 0, nlog = 0;
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];

  always #4 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_flat
    assign redir_flat[i*64 +: 64] = ent[i];
  end

  irq_route_engine u_irq_route_engine (
    .clk(clk), .rst(rst), .irq_in(irq_in), .redir_flat(redir_flat),
    .redir_upd(redir_upd), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .remote_irr(remote_irr)
  );

  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready && nlog < 16) begin
      log_addr[nlog] = msg_addr;
      log_data[nlog] = msg_data;
      nlog = nlog + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_entry(input int pin, input logic [7:0] vec, input logic [2:0] dlv,
                           input logic dm, input logic lvl, input logic msk, input logic [15:0] dest);
    ent[pin] = {dest, 31'b0, msk, lvl, 3'b0, dm, dlv, vec};
    redir_upd = 1'b1;
    tick(1);
    redir_upd = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_vector = v; eoi_valid = 1'b1;
    tick(1);
    eoi_valid = 1'b0;
  endtask

  task automatic pulse(input int line);
    irq_in[line] = 1'b1; tick(2); irq_in[line] = 1'b0;
  endtask

  task automatic t_reset;
    check(msg_valid == 1'b0, "R11 valid after reset", 32'(msg_valid), 0);
    check(remote_irr == '0, "R11 remote_irr after reset", 32'(remote_irr), 0);
  endtask

  task automatic t_steer;
    set_entry(2, 8'h42, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    set_entry(0, 8'h30, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    tick(60); nlog = 0;
    pulse(0); tick(60);
    check(nlog == 1, "R1 one message from line 0", 32'(nlog), 1);
    check(log_data[0][7:0] == 8'h42, "R1 steered to pin 2 vector", {24'h0, log_data[0][7:0]}, 32'h42);
    set_entry(0, 8'h30, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    set_entry(2, 8'h42, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
  endtask

  task automatic t_format;
    set_entry(5, 8'h91, 3'd1, 1'b1, 1'b0, 1'b0, 16'hABCD);
    tick(60); nlog = 0;
    pulse(5); tick(60);
    check(nlog == 1, "R5 single edge delivery", 32'(nlog), 1);
    check(log_addr[0] == 32'hFEEABCD4, "R7 address", log_addr[0], 32'hFEEABCD4);
    check(log_data[0] == 32'h00000191, "R7 data", log_data[0], 32'h00000191);
    tick(60);
    check(nlog == 1, "R5 no repeat", 32'(nlog), 1);
  endtask

  task automatic t_edge_masked;
    set_entry(6, 8'h55, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    tick(60); nlog = 0;
    pulse(6); tick(60);
    check(nlog == 0, "R4 masked edge dropped", 32'(nlog), 0);
    set_entry(6, 8'h55, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    tick(60);
    check(nlog == 0, "R4 unmask sends nothing", 32'(nlog), 0);
  endtask

  task automatic t_level;
    set_entry(9, 8'h60, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0);
    tick(60); nlog = 0;
    irq_in[9] = 1'b1; tick(60);
    check(nlog == 1, "R2 level delivered once", 32'(nlog), 1);
    check(log_data[0] == 32'h00008060, "R7 level data", log_data[0], 32'h00008060);
    check(remote_irr[9] == 1'b1, "R3 remote_irr set", 32'(remote_irr[9]), 1);
    tick(60);
    check(nlog == 1, "R3 blocked while in service", 32'(nlog), 1);
    eoi(8'h61); tick(60);
    check(nlog == 1 && remote_irr[9], "R3 other vector no effect", 32'(nlog), 1);
    eoi(8'h60); tick(60);
    check(nlog == 2, "R3 redelivered after matching eoi", 32'(nlog), 2);
    check(remote_irr[9] == 1'b1, "R3 remote_irr set again", 32'(remote_irr[9]), 1);
    irq_in[9] = 1'b0; tick(5);
    eoi(8'h60); tick(60);
    check(nlog == 2, "R2 low line not redelivered", 32'(nlog), 2);
    check(remote_irr[9] == 1'b0, "R3 remote_irr cleared", 32'(remote_irr[9]), 0);
    irq_in[9] = 1'b1; tick(60);
    check(remote_irr[9] == 1'b1, "R10 setup remote_irr", 32'(remote_irr[9]), 1);
    set_entry(9, 8'h60, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    tick(2);
    check(remote_irr[9] == 1'b0, "R10 edge clears remote_irr", 32'(remote_irr[9]), 0);
    irq_in[9] = 1'b0; tick(60);
  endtask

  task automatic t_masked_level;
    set_entry(12, 8'h70, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0);
    tick(60); nlog = 0;
    irq_in[12] = 1'b1; tick(60);
    check(nlog == 0, "R6 masked level silent", 32'(nlog), 0);
    set_entry(12, 8'h70, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0);
    tick(60);
    check(nlog == 1 && log_data[0] == 32'h00008070, "R6 unmasked delivered", log_data[0], 32'h00008070);
    irq_in[12] = 1'b0; tick(5); eoi(8'h70);
    set_entry(12, 8'h70, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0);
    tick(60);
  endtask

  task automatic t_order;
    set_entry(3, 8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    set_entry(7, 8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    tick(60); nlog = 0;
    irq_in[7] = 1'b1; irq_in[3] = 1'b1; tick(2); irq_in = '0; tick(60);
    check(nlog == 2, "R8 two messages", 32'(nlog), 2);
    check(log_data[0][7:0] == 8'h33, "R8 lower pin first", log_data[0], 32'h33);
    check(log_data[1][7:0] == 8'h77, "R8 higher pin second", log_data[1], 32'h77);
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    nlog = 0; msg_ready = 1'b0;
    irq_in[7] = 1'b1; irq_in[3] = 1'b1; tick(2); irq_in = '0; tick(40);
    check(msg_valid == 1'b1, "R9 valid under stall", 32'(msg_valid), 1);
    held = msg_data;
    check(held == 32'h33, "R9 first held message", held, 32'h33);
    tick(20);
    check(msg_valid && msg_data == held, "R9 held stable", msg_data, held);
    check(nlog == 0, "R9 nothing taken", 32'(nlog), 0);
    msg_ready = 1'b1; tick(60);
    check(nlog == 2 && log_data[1] == 32'h77, "R9 second after release", log_data[1], 32'h77);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) ent[i] = 64'h0000_0000_0001_0000;
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_steer();
    t_format();
    t_edge_masked();
    t_level();
    t_masked_level();
    t_order();
    t_backpressure();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule